// File: doc/BRIEF.md
# Three-Port Register File with Constant Entries

This block holds the sixteen 16-bit general registers of a small multicycle processor. Three read ports, each selected by a 4-bit index, return register contents combinationally and independently, so the operand-fetch step can pick up all three source operands in a single cycle. One write port, with its own index, data and enable, updates a register on the rising clock edge.

The two lowest entries are not storage. Index 0 always reads zero and index 1 always reads one. The processor can use these values as ready-made operands without loading them first. Writes to either index are dropped without any error. The entry at index 5 holds the interrupt handler address, and the processor loads it into the program counter on interrupt entry. That entry is driven onto a dedicated output at all times. Index 15 serves as the stack pointer but is otherwise an ordinary register. An active-low asynchronous reset clears every writable entry.

Top module: `rf3_regfile`

## Requirements
- R1: There are 16 entries of 16 bits, addressed by 4-bit indices. Three read ports each return the entry selected by their own index at the same time, and any combination of indices is allowed, including the same index on more than one port.
- R2: Index 0 reads 0x0000 on every read port at all times, including after any write addressed to it.
- R3: Index 1 reads 0x0001 on every read port at all times, including after any write addressed to it.
- R4: A write with we_i high and wr_idx_i equal to 0 or 1 is discarded. It changes no entry and raises no signal.
- R5: When we_i is high and wr_idx_i is between 2 and 15, the entry at wr_idx_i takes wr_data_i on the rising clock edge. The new value is readable from the next cycle on.
- R6: Reads are combinational. A read of the index being written in the same cycle returns the value held before that edge.
- R7: While we_i is low, no entry changes, whatever wr_idx_i and wr_data_i carry.
- R8: While rst_ni is low, entries 2 to 15 are cleared to 0x0000. The clear is asynchronous and does not wait for a clock edge.
- R9: handler_addr_o always shows the contents of entry 5. It changes only in the cycle after a write to index 5, or on reset.
- R10: Entry 15, the stack pointer, stores and returns the full 16-bit range like any other writable entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes land on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd0_idx_i | input | 4 | Index for read port 0 |
| rd0_data_o | output | 16 | Data from read port 0 |
| rd1_idx_i | input | 4 | Index for read port 1 |
| rd1_data_o | output | 16 | Data from read port 1 |
| rd2_idx_i | input | 4 | Index for read port 2 |
| rd2_data_o | output | 16 | Data from read port 2 |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 16 | Write data |
| handler_addr_o | output | 16 | Current contents of entry 5 |

## Verification
The properties assume that the write inputs and the read indices are stable at the sampling edge. They also assume that rst_ni stays high across the edge after a write, so that the one-cycle write-to-read relation is not cut by a reset. The bench changes every input at the falling edge. It pulses reset only in cycles where no write is pending. It compares each read against its model before the next rising edge, which also covers the same-cycle read of a register being written.

// File: rtl/rf3_pkg.sv
package rf3_pkg;
  localparam int unsigned RF_DEPTH   = 16;
  localparam int unsigned RF_WIDTH   = 16;
  localparam int unsigned RF_IDX_W   = $clog2(RF_DEPTH);
  localparam int unsigned RF_NCONST  = 2;
  localparam int unsigned RF_HANDLER = 5;

  // constant entry i reads as the value i
  function automatic logic [RF_WIDTH-1:0] const_word(int unsigned i);
    return RF_WIDTH'(i);
  endfunction
endpackage

// File: rtl/rf3_wr_dec.sv
module rf3_wr_dec #(
  parameter int unsigned DEPTH  = rf3_pkg::RF_DEPTH,
  parameter int unsigned NCONST = rf3_pkg::RF_NCONST,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic [DEPTH-1:0] wr_en_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    if (i < NCONST) begin : g_ro
      assign wr_en_o[i] = 1'b0;
    end else begin : g_rw
      assign wr_en_o[i] = we_i && (wr_idx_i == IDX_W'(i));
    end
  end
endmodule

// File: rtl/rf3_store.sv
module rf3_store #(
  parameter int unsigned DEPTH  = rf3_pkg::RF_DEPTH,
  parameter int unsigned WIDTH  = rf3_pkg::RF_WIDTH,
  parameter int unsigned NCONST = rf3_pkg::RF_NCONST
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:0]            wr_en_i,
  input  logic [WIDTH-1:0]            wr_data_i,
  output logic [DEPTH-1:0][WIDTH-1:0] regs_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < NCONST) begin : g_const
      assign regs_o[i] = WIDTH'(i);
    end else begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (wr_en_i[i]) q <= wr_data_i;
      end
      assign regs_o[i] = q;
    end
  end

  logic unused_en;
  assign unused_en = ^wr_en_i[NCONST-1:0];
endmodule

// File: rtl/rf3_rd_port.sv
module rf3_rd_port #(
  parameter int unsigned DEPTH  = rf3_pkg::RF_DEPTH,
  parameter int unsigned WIDTH  = rf3_pkg::RF_WIDTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] regs_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [WIDTH-1:0]            data_o
);
  assign data_o = regs_i[idx_i];
endmodule

// File: rtl/rf3_regfile.sv
module rf3_regfile #(
  parameter int unsigned DEPTH       = rf3_pkg::RF_DEPTH,
  parameter int unsigned WIDTH       = rf3_pkg::RF_WIDTH,
  parameter int unsigned NCONST      = rf3_pkg::RF_NCONST,
  parameter int unsigned HANDLER_IDX = rf3_pkg::RF_HANDLER,
  localparam int unsigned IDX_W      = $clog2(DEPTH),
  localparam int unsigned NRD        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd0_idx_i,
  output logic [WIDTH-1:0] rd0_data_o,
  input  logic [IDX_W-1:0] rd1_idx_i,
  output logic [WIDTH-1:0] rd1_data_o,
  input  logic [IDX_W-1:0] rd2_idx_i,
  output logic [WIDTH-1:0] rd2_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] handler_addr_o
);
  logic [DEPTH-1:0]            wr_en;
  logic [DEPTH-1:0][WIDTH-1:0] regs;
  logic [NRD-1:0][IDX_W-1:0]   rd_idx;
  logic [NRD-1:0][WIDTH-1:0]   rd_data;

  rf3_wr_dec #(.DEPTH(DEPTH), .NCONST(NCONST)) u_dec (
    .we_i     (we_i),
    .wr_idx_i (wr_idx_i),
    .wr_en_o  (wr_en)
  );

  rf3_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NCONST(NCONST)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  assign rd_idx[0] = rd0_idx_i;
  assign rd_idx[1] = rd1_idx_i;
  assign rd_idx[2] = rd2_idx_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf3_rd_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_port (
      .regs_i (regs),
      .idx_i  (rd_idx[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd0_data_o     = rd_data[0];
  assign rd1_data_o     = rd_data[1];
  assign rd2_data_o     = rd_data[2];
  assign handler_addr_o = regs[HANDLER_IDX];
endmodule

// File: rtl/rf3_regfile_chk.sv
module rf3_regfile_chk #(
  parameter int unsigned WIDTH       = rf3_pkg::RF_WIDTH,
  parameter int unsigned IDX_W       = rf3_pkg::RF_IDX_W,
  parameter int unsigned HANDLER_IDX = rf3_pkg::RF_HANDLER
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] rd0_idx_i,
  input logic [WIDTH-1:0] rd0_data_o,
  input logic [IDX_W-1:0] rd1_idx_i,
  input logic [WIDTH-1:0] rd1_data_o,
  input logic [IDX_W-1:0] rd2_idx_i,
  input logic [WIDTH-1:0] rd2_data_o,
  input logic             we_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] handler_addr_o
);
  p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_idx_i == '0) |-> (rd0_data_o == '0));
  p_zero_p2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd2_idx_i == '0) |-> (rd2_data_o == '0));
  p_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1_idx_i == IDX_W'(1)) |-> (rd1_data_o == WIDTH'(1)));
  p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i > IDX_W'(1)) |=>
      (rd0_idx_i != $past(wr_idx_i) || rd0_data_o == $past(wr_data_i)));
  p_handler_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i == IDX_W'(HANDLER_IDX)) |=> (handler_addr_o == $past(wr_data_i)));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(handler_addr_o));
endmodule

bind rf3_regfile rf3_regfile_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .HANDLER_IDX(HANDLER_IDX)) u_chk (.*);

// File: tb/rf3_regfile_test.sv
`timescale 1ns/1ps
module rf3_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, rd2_idx = '0, wr_idx = '0;
  logic [15:0] rd0_data, rd1_data, rd2_data, handler, wr_data = '0;
  logic        we = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int model [16];

  always #2 clk = ~clk;

  rf3_regfile uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd0_idx_i(rd0_idx), .rd0_data_o(rd0_data),
    .rd1_idx_i(rd1_idx), .rd1_data_o(rd1_data),
    .rd2_idx_i(rd2_idx), .rd2_data_o(rd2_data),
    .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .handler_addr_o(handler)
  );

  function automatic int ref_read(int i);
    if (i == 0) return 0;
    if (i == 1) return 1;
    return model[i];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, int'(rd0_data), ref_read(int'(rd0_idx)));
    chk(tag, int'(rd1_data), ref_read(int'(rd1_idx)));
    chk(tag, int'(rd2_data), ref_read(int'(rd2_idx)));
    chk({tag, " R9"}, int'(handler), model[5]);
  endtask

  // drive at negedge, compare pre-edge state, then apply the edge to the model
  task automatic step(string tag, bit w, int wi, int wd, int a, int b, int c);
    @(negedge clk);
    we = w; wr_idx = 4'(wi); wr_data = 16'(wd);
    rd0_idx = 4'(a); rd1_idx = 4'(b); rd2_idx = 4'(c);
    #1 compare(tag);
    @(posedge clk);
    if (w && wi > 1) model[wi] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0;
    rst_n = 1'b0;
    #1;
    for (int i = 2; i < 16; i++) model[i] = 0;
    compare("R8");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // reset state across all indices (R8, R2, R3)
    for (int i = 0; i < 16; i++) step("R8 reset", 0, 0, 0, i, (i + 5) % 16, (i + 11) % 16);
    // fill writable entries, same-cycle read sees old value (R6)
    for (int i = 2; i < 16; i++) step("R6", 1, i, 16'hA000 + i * 16'h0111, i, i, i);
    // rotated simultaneous reads (R1, R5)
    for (int i = 0; i < 16; i++) step("R1 R5", 0, 0, 0, i, 15 - i, (i * 7) % 16);
    // writes to constant entries discarded (R4, R2, R3)
    step("R4", 1, 0, 16'hDEAD, 0, 1, 2);
    step("R4", 1, 1, 16'hBEEF, 0, 1, 2);
    for (int i = 0; i < 16; i++) step("R4 R2 R3", 0, 0, 0, i, 0, 1);
    // enable low: nothing moves (R7)
    for (int i = 0; i < 16; i++) step("R7", 0, i, 16'h5A5A ^ i, i, 5, (i + 3) % 16);
    for (int i = 0; i < 16; i++) step("R7", 0, 0, 0, i, 5, 15);
    // handler entry output (R9)
    step("R9", 1, 5, 16'h1234, 5, 5, 5);
    step("R9", 0, 0, 0, 5, 5, 5);
    step("R9", 1, 5, 16'hFEDC, 5, 0, 1);
    step("R9", 0, 0, 0, 5, 0, 1);
    // stack pointer full range (R10)
    step("R10", 1, 15, 16'hFFFF, 15, 15, 15);
    step("R10", 1, 15, 16'h8000, 15, 15, 15);
    step("R10", 1, 15, 16'h0001, 15, 15, 15);
    step("R10", 0, 0, 0, 15, 15, 15);
    // mixed traffic (R1, R5)
    for (int n = 0; n < 300; n++)
      step("R1 R5 mix", bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    // asynchronous reset mid-run (R8)
    do_reset();
    for (int i = 0; i < 16; i++) step("R8 after", 0, 0, 0, i, i, 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule